// File: doc/BRIEF.md
# Read/Write Strobe Bus Sequencer

This block turns single transfer requests from inside the chip into cycles on a synchronous external bus. The external bus has separate address and data lines and a bus-clock-aligned read strobe and write strobe. Each direction can be set to one of two timings. In one-cycle timing, the address, the strobe and the data all share one bus clock. In two-cycle timing, the address goes out with its strobe in one clock, and the data is driven or captured in the clock after it, with the strobe low.

A small configuration register holds three bits: the strobe enable, the two-cycle read select and the two-cycle write select. Setting either two-cycle select forces the strobes on, whatever the strobe-enable bit holds. On the internal side, a request is accepted on any clock edge where both valid and ready are high. Ready is also high during the final bus cycle of a transfer, so consecutive requests run with no idle clock between them. Read data comes back with a one-clock valid pulse in the clock after it is captured.

Top module: `strobe_bus_seq`

## Requirements
- R1: After reset, all three configuration bits are 0. While idle, req_ready is 1 and rsp_valid, bus_rd, bus_wr, bus_strb_oe and bus_dout_oe are all 0.
- R2: While the effective strobe enable is 0, bus_strb_oe, bus_rd and bus_wr stay 0 through reads and writes.
- R3: From the clock after a cfg_load edge, bus_strb_oe equals (strobe enable OR two-cycle read OR two-cycle write), using the loaded values.
- R4: A request accepted at an edge makes the next clock its address cycle. bus_addr carries the request address, and bus_rd (for a read, req_write=0) or bus_wr (for a write, req_write=1) is high in that cycle only, when strobes are enabled.
- R5: A one-cycle write drives bus_dout with the write data and sets bus_dout_oe to 1 in the address cycle itself. req_ready is 1 in that cycle.
- R6: A two-cycle write has bus_wr high, bus_dout_oe 0 and req_ready 0 in its address cycle. In the next clock, bus_wr is 0, bus_dout_oe is 1, bus_dout holds the data and req_ready is 1.
- R7: A one-cycle read captures bus_din at the edge that ends its address cycle, so bus_rd is high in the capture cycle. rsp_valid is 1 and rsp_rdata holds that value in the following clock, and rsp_valid is 0 the clock after that.
- R8: A two-cycle read has req_ready 0 in its address cycle. In the second clock bus_rd is 0 and req_ready is 1, and bus_din is captured at the edge that ends that clock. The response follows as in R7.
- R9: bus_dout_oe is 0 in every read cycle and whenever the sequencer is idle.
- R10: A request presented while a transfer is in its final cycle is accepted at that edge. Its address cycle follows in the very next clock, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Loads the three configuration bits |
| cfg_strobe_en | input | 1 | Strobe enable bit to load |
| cfg_rd_two | input | 1 | Two-cycle read select to load |
| cfg_wr_two | input | 1 | Two-cycle write select to load |
| req_valid | input | 1 | Request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer can take a request at this edge |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Returned read data |
| bus_addr | output | ADDR_W | External address lines |
| bus_dout | output | DATA_W | External data lines, outgoing |
| bus_dout_oe | output | 1 | Output enable for the data lines |
| bus_din | input | DATA_W | External data lines, incoming |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_strb_oe | output | 1 | Strobe pins driven (effective strobe enable) |

## Verification
The bench builds the block with ADDR_W=12 and DATA_W=16 rather than the defaults. It drives a different bus_din value in each clock around a read, so a capture one clock early or one clock late returns a visibly wrong word. The configurations it steps through cover all four timing combinations, the forced strobe enable from each two-cycle select on its own, and the fully disabled strobe case. Requests are also held valid across transfer ends, which reaches the back-to-back hand-off for both one-cycle and two-cycle timing.

// File: rtl/sbs_pkg.sv
// Shared types for the strobe bus sequencer.
package sbs_pkg;
    // Bus phase of the transfer in progress.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/sbs_cfg_reg.sv
// Configuration register for the sequencer.
// Holds the strobe enable and the two-cycle selects. Produces the effective
// strobe enable, which is forced on by either two-cycle select.
// Assumes: load is a single-clock request; all bits reset to 0.
module sbs_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic strobe_in,
    input  logic rd_two_in,
    input  logic wr_two_in,
    output logic rd_two_o,
    output logic wr_two_o,
    output logic strb_eff_o
);
    logic strobe_q;
    logic rd_two_q;
    logic wr_two_q;

    // Capture new configuration on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            rd_two_q <= 1'b0;
            wr_two_q <= 1'b0;
        end else if (load) begin
            strobe_q <= strobe_in;
            rd_two_q <= rd_two_in;
            wr_two_q <= wr_two_in;
        end
    end

    // Effective strobe enable: any two-cycle select forces it.
    always_comb begin
        rd_two_o   = rd_two_q;
        wr_two_o   = wr_two_q;
        strb_eff_o = strobe_q | rd_two_q | wr_two_q;
    end
endmodule

// File: rtl/sbs_phase_fsm.sv
// Phase sequencer: accepts a request, holds its fields, and steps through
// the address cycle and, for two-cycle timing, the data cycle.
// Assumes: the two-cycle selects are sampled in the address cycle; ready
// never depends on req_valid, so there is no input-to-output path.
module sbs_phase_fsm
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_two,
    input  logic              wr_two,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              addr_cyc_o,
    output logic              write_o,
    output logic              data_drive_o,
    output logic              capture_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    phase_e            phase_q;
    phase_e            phase_d;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              two_cur;
    logic              last_cyc;
    logic              accept;
    logic              in_addr;
    logic              in_data;

    // Decode the current phase and whether it ends the transfer.
    always_comb begin
        in_addr   = (phase_q == PH_ADDR);
        in_data   = (phase_q == PH_DATA);
        two_cur   = write_q ? wr_two : rd_two;
        last_cyc  = (in_addr && !two_cur) || in_data;
        req_ready = (phase_q == PH_IDLE) || last_cyc;
        accept    = req_valid && req_ready;
    end

    // Next-phase selection.
    always_comb begin
        if (accept) begin
            phase_d = PH_ADDR;
        end else begin
            case (phase_q)
                PH_ADDR: phase_d = two_cur ? PH_DATA : PH_IDLE;
                PH_DATA: phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Request field holding registers, loaded on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Per-cycle bus intents handed to the pin driver and the read capture.
    always_comb begin
        addr_cyc_o   = in_addr;
        write_o      = write_q;
        data_drive_o = write_q && ((in_addr && !wr_two) || in_data);
        capture_o    = !write_q && ((in_addr && !rd_two) || in_data);
        addr_o       = addr_q;
        wdata_o      = wdata_q;
    end
endmodule

// File: rtl/sbs_pin_drive.sv
// Pin driver: forms the strobes and the data-line output enable from the
// phase intents and the effective strobe enable.
// Assumes: intents come from registers, so pins change only after clock edges.
module sbs_pin_drive (
    input  logic strb_eff,
    input  logic addr_cyc,
    input  logic write,
    input  logic data_drive,
    output logic bus_rd,
    output logic bus_wr,
    output logic bus_dout_oe,
    output logic bus_strb_oe
);
    // Strobes are high only in the address cycle and only when enabled.
    always_comb begin
        bus_strb_oe = strb_eff;
        bus_rd      = strb_eff && addr_cyc && !write;
        bus_wr      = strb_eff && addr_cyc && write;
        bus_dout_oe = data_drive;
    end
endmodule

// File: rtl/sbs_rd_capture.sv
// Read capture: samples the incoming data lines at the edge that ends a
// capture cycle and presents them with a one-clock valid pulse.
// Assumes: bus_din is stable around the capture edge.
module sbs_rd_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Capture register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= din;
            end
        end
    end
endmodule

// File: rtl/strobe_bus_seq.sv
// Read/write strobe bus sequencer top.
// Sequences single transfers from an internal valid/ready request port onto
// a synchronous external bus, with one- or two-cycle timing per direction.
// Assumes: synchronous active-low reset; bus_din is synchronous to clk.
module strobe_bus_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_strobe_en,
    input  logic              cfg_rd_two,
    input  logic              cfg_wr_two,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_oe,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_strb_oe
);
    logic rd_two_q;
    logic wr_two_q;
    logic strb_eff;
    logic addr_cyc;
    logic cur_write;
    logic data_drive;
    logic capture;

    sbs_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .strobe_in  (cfg_strobe_en),
        .rd_two_in  (cfg_rd_two),
        .wr_two_in  (cfg_wr_two),
        .rd_two_o   (rd_two_q),
        .wr_two_o   (wr_two_q),
        .strb_eff_o (strb_eff)
    );

    sbs_phase_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_two       (rd_two_q),
        .wr_two       (wr_two_q),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .addr_cyc_o   (addr_cyc),
        .write_o      (cur_write),
        .data_drive_o (data_drive),
        .capture_o    (capture),
        .addr_o       (bus_addr),
        .wdata_o      (bus_dout)
    );

    sbs_pin_drive u_pins (
        .strb_eff    (strb_eff),
        .addr_cyc    (addr_cyc),
        .write       (cur_write),
        .data_drive  (data_drive),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_dout_oe (bus_dout_oe),
        .bus_strb_oe (bus_strb_oe)
    );

    sbs_rd_capture #(
        .DATA_W (DATA_W)
    ) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .din       (bus_din),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/strobe_bus_seq_chk.sv
// Property checker for the strobe bus sequencer, bound to the top.
// Observes ports plus the loaded two-cycle selects.
module strobe_bus_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_dout_oe,
    input logic              bus_strb_oe,
    input logic              rd_two,
    input logic              wr_two
);
    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strb_oe |-> (!bus_rd && !bus_wr)); // R2

    AST_ACCEPT_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_addr == $past(req_addr))); // R10

    AST_WR2_ADDR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wr_two) |-> (!req_ready && !bus_dout_oe)); // R6

    AST_WR2_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wr_two) |=> (bus_dout_oe && !bus_wr && req_ready)); // R6

    AST_RD2_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rd_two) |=> (!bus_rd && !bus_dout_oe && req_ready)); // R8

    AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !bus_dout_oe); // R9
endmodule

bind strobe_bus_seq strobe_bus_seq_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_dout_oe (bus_dout_oe),
    .bus_strb_oe (bus_strb_oe),
    .rd_two      (rd_two_q),
    .wr_two      (wr_two_q)
);

// File: tb/strobe_bus_seq_tb.sv
// Directed bench for the strobe bus sequencer.
module strobe_bus_seq_tb;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic          cfg_strobe_en = 1'b0;
    logic          cfg_rd_two = 1'b0;
    logic          cfg_wr_two = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_oe;
    logic [DW-1:0] bus_din = '0;
    logic          bus_rd;
    logic          bus_wr;
    logic          bus_strb_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic m_strb = 1'b0;
    logic m_rd2 = 1'b0;
    logic m_wr2 = 1'b0;

    always #2 clk = ~clk;

    strobe_bus_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        eq("R1 ready", 32'(req_ready), 1);
        eq("R1 rsp_valid", 32'(rsp_valid), 0);
        eq("R1 strobes", {30'd0, bus_rd, bus_wr}, 0);
        eq("R1 strb_oe", 32'(bus_strb_oe), 0);
        eq("R1 dout_oe", 32'(bus_dout_oe), 0);
    endtask

    task automatic set_cfg(input logic s, input logic r, input logic w);
        @(negedge clk);
        cfg_load = 1'b1; cfg_strobe_en = s; cfg_rd_two = r; cfg_wr_two = w;
        @(negedge clk);
        cfg_load = 1'b0; #1;
        m_strb = s | r | w; m_rd2 = r; m_wr2 = w;
        eq("R3 strb_oe", 32'(bus_strb_oe), 32'(m_strb));
    endtask

    task automatic idle_check();
        @(negedge clk); #1;
        eq("R9 idle dout_oe", 32'(bus_dout_oe), 0);
        eq("R4 idle strobes", {30'd0, bus_rd, bus_wr}, 0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; #1;
        eq("R10 ready before write", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0; #1;
        eq("R4 write addr", 32'(bus_addr), 32'(a));
        eq("R4 R2 wr strobe", 32'(bus_wr), 32'(m_strb));
        eq("R4 rd low on write", 32'(bus_rd), 0);
        if (!m_wr2) begin
            eq("R5 dout_oe", 32'(bus_dout_oe), 1);
            eq("R5 dout", 32'(bus_dout), 32'(d));
            eq("R5 ready", 32'(req_ready), 1);
        end else begin
            eq("R6 addr cycle dout_oe", 32'(bus_dout_oe), 0);
            eq("R6 addr cycle ready", 32'(req_ready), 0);
            @(negedge clk); #1;
            eq("R6 data cycle wr", 32'(bus_wr), 0);
            eq("R6 data cycle dout_oe", 32'(bus_dout_oe), 1);
            eq("R6 data cycle dout", 32'(bus_dout), 32'(d));
            eq("R6 data cycle ready", 32'(req_ready), 1);
        end
        idle_check();
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; bus_din = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        bus_din = m_rd2 ? 16'hBEEF : d; #1;
        eq("R4 read addr", 32'(bus_addr), 32'(a));
        eq("R4 R2 rd strobe", 32'(bus_rd), 32'(m_strb));
        eq("R9 read dout_oe", 32'(bus_dout_oe), 0);
        eq("R7 no early rsp", 32'(rsp_valid), 0);
        if (m_rd2) begin
            eq("R8 addr cycle ready", 32'(req_ready), 0);
            @(negedge clk);
            bus_din = d; #1;
            eq("R8 second cycle rd", 32'(bus_rd), 0);
            eq("R8 second cycle ready", 32'(req_ready), 1);
            eq("R9 second cycle dout_oe", 32'(bus_dout_oe), 0);
            eq("R8 no early rsp", 32'(rsp_valid), 0);
        end
        @(negedge clk);
        bus_din = 16'h0BAD; #1;
        eq("R7 R8 rsp_valid", 32'(rsp_valid), 1);
        eq("R7 R8 rsp_rdata", 32'(rsp_rdata), 32'(d));
        eq("R9 idle dout_oe", 32'(bus_dout_oe), 0);
        @(negedge clk); #1;
        eq("R7 rsp pulse ends", 32'(rsp_valid), 0);
    endtask

    // Two writes presented back to back; second must start right after the first's last cycle.
    task automatic t_b2b(input logic [AW-1:0] a0, input logic [AW-1:0] a1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a0; req_wdata = 16'h1111;
        @(negedge clk); #1;
        eq("R10 first addr", 32'(bus_addr), 32'(a0));
        if (m_wr2) begin
            eq("R10 held while not ready", 32'(req_ready), 0);
            @(negedge clk); #1;
        end
        req_addr = a1; req_wdata = 16'h2222;
        eq("R10 ready in last cycle", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0; #1;
        eq("R10 second addr next clock", 32'(bus_addr), 32'(a1));
        eq("R10 wr strobe again", 32'(bus_wr), 32'(m_strb));
        if (m_wr2) begin
            @(negedge clk); #1;
        end
        eq("R10 second data", 32'(bus_dout), 32'h2222);
        idle_check();
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        set_cfg(1'b0, 1'b0, 1'b0);
        t_write(12'h123, 16'hA001);
        t_read(12'h124, 16'h5A5A);
        set_cfg(1'b1, 1'b0, 1'b0);
        t_write(12'h200, 16'hC0DE);
        t_read(12'h201, 16'h1234);
        set_cfg(1'b0, 1'b0, 1'b1);
        t_write(12'h300, 16'hFACE);
        t_read(12'h301, 16'h4321);
        set_cfg(1'b0, 1'b1, 1'b0);
        t_read(12'h400, 16'h9876);
        t_write(12'h401, 16'h0F0F);
        set_cfg(1'b1, 1'b0, 1'b0);
        t_b2b(12'h500, 12'h501);
        set_cfg(1'b1, 1'b1, 1'b1);
        t_b2b(12'h600, 12'h601);
        t_read(12'h602, 16'hAAAA);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule